// File: doc/BRIEF.md
# BCD Clock-Calendar Counter

This block holds a time of day and a calendar date as seven packed-BCD bytes and advances them by one second on every pulse of a once-per-second tick input. The bytes cover seconds, minutes, hours, day of week, day of month, month and a two-digit year. Rollovers pass from field to field: seconds to minutes, minutes to hours, hours to both day counters, date to month, and month to year. Month lengths follow the calendar, including leap Februaries.

The hours byte runs in one of two formats, picked by a bit stored in that byte. In the 24-hour format the byte counts 00 to 23. In the 12-hour format it counts 1 to 12 and carries a PM flag. The top bit of the seconds byte is a halt flag, and while it is set the tick does nothing. A host loads any field through a single-cycle write strobe that carries a field index and a data byte. All seven bytes are visible on the output ports at all times.

Top module: `bcd_clock_calendar`

## Requirements
- R1: After reset the outputs are: seconds 0x00 (halt clear), minutes 0x00, hours 0x00 (24-hour format), day of week 0x01, date 0x01, month 0x01, year 0x00.
- R2: Seconds and minutes are BCD values from 00 to 59. A tick advances the seconds by one. Seconds at 59 wrap to 00 and advance the minutes. Minutes at 59 wrap to 00 and advance the hours.
- R3: While bit 7 of the seconds byte is 1, a tick changes no byte. When that bit is 0, ticks advance the time.
- R4: When bit 6 of the hours byte is 0 (24-hour format), bits 5:0 hold a BCD hour from 00 to 23. Hour 23 wraps to 00, and that wrap is midnight.
- R5: When bit 6 of the hours byte is 1 (12-hour format), bit 5 is the PM flag (1 = PM) and bits 4:0 hold a BCD hour from 01 to 12. Hour 11 goes to 12 and toggles the flag. Hour 12 goes to 01 and keeps the flag. Midnight is the step from 11 PM to 12 AM.
- R6: At midnight the day of week (byte values 1 to 7) advances by one and wraps from 7 to 1.
- R7: At midnight the date advances. The date wraps to 01 after the last day of the month. April, June, September and November have 30 days. February has 29 days when the year is divisible by 4 and 28 days otherwise. All other months have 31 days.
- R8: A date wrap advances the month. Month 12 wraps to 01 and advances the year. Year 99 wraps to 00.
- R9: A write with wr_en_i high loads the field selected by wr_addr_i (0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year) in the next cycle. Bits that must be zero are cleared on the write: bit 7 of minutes and hours, bits 7:3 of day of week, bits 7:6 of date and bits 7:5 of month. Index 7 changes nothing.
- R10: When a write and a tick arrive in the same cycle, the written field takes the written value. The other fields advance, with carries worked out from the values held before that cycle.
- R11: With no tick and no write, every byte holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse, once per second |
| wr_en_i | input | 1 | Host write strobe |
| wr_addr_i | input | 3 | Field index for the write |
| wr_data_i | input | 8 | Write data byte |
| sec_o | output | 8 | Halt flag and BCD seconds |
| min_o | output | 8 | BCD minutes |
| hour_o | output | 8 | Format bit, PM or tens bit, BCD hour |
| wday_o | output | 8 | Day of week |
| date_o | output | 8 | BCD day of month |
| month_o | output | 8 | BCD month |
| year_o | output | 8 | BCD year |

## Verification
The hardest states to reach are the deep carries: a year or month rollover, a leap-day February, and a midnight in 12-hour format. From reset, ticks alone would take millions of cycles to get there. The stimulus therefore loads each field to one tick before the boundary and then applies a single tick. The random phase also favours the values 59, 23, 11 and 12 in its writes, so that carries keep crossing field boundaries, often in the same cycle as a write.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned N_FLD  = 7;

  typedef logic [BYTE_W-1:0] bcd8_t;

  typedef enum logic [ADDR_W-1:0] {
    F_SEC   = 3'd0,
    F_MIN   = 3'd1,
    F_HOUR  = 3'd2,
    F_WDAY  = 3'd3,
    F_DATE  = 3'd4,
    F_MONTH = 3'd5,
    F_YEAR  = 3'd6
  } fld_e;

  function automatic bcd8_t bcd_inc(input bcd8_t v);
    bcd8_t r;
    if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // tens*10 mod 4 equals 2 for odd tens, ones mod 4 is the low two bits
  function automatic logic is_leap(input bcd8_t y);
    logic [1:0] r;
    r = (y[4] ? 2'd2 : 2'd0) + y[1:0];
    return r == 2'd0;
  endfunction

  function automatic bcd8_t last_day(input bcd8_t m, input bcd8_t y);
    bcd8_t r;
    case (m)
      8'h02:                      r = is_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
      default:                    r = 8'h31;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/bcd_field_cnt.sv
module bcd_field_cnt
  import bcd_cal_pkg::*;
#(
  parameter bcd8_t LO   = 8'h00,
  parameter bcd8_t RST  = 8'h00,
  parameter bcd8_t MASK = 8'hFF
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  inc_i,
  input  bcd8_t top_i,
  input  logic  wr_i,
  input  bcd8_t wr_data_i,
  output bcd8_t val_o,
  output logic  wrap_o
);
  bcd8_t q;

  assign wrap_o = inc_i && (q == top_i);
  assign val_o  = q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= RST;
    else if (wr_i)   q <= wr_data_i & MASK;
    else if (inc_i)  q <= wrap_o ? LO : bcd_inc(q);
  end
endmodule

// File: rtl/bcd_hour_cnt.sv
module bcd_hour_cnt
  import bcd_cal_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  inc_i,
  input  logic  wr_i,
  input  bcd8_t wr_data_i,
  output bcd8_t val_o,
  output logic  day_o
);
  logic [6:0] q, nxt;
  logic       mid;
  bcd8_t      inc12, inc24;

  assign inc12 = bcd_inc({3'b000, q[4:0]});
  assign inc24 = bcd_inc({2'b00, q[5:0]});

  always_comb begin
    nxt = q;
    mid = 1'b0;
    if (q[6]) begin
      // 12h: bit5 = PM
      case (q[4:0])
        5'h11: begin
          nxt[5]   = ~q[5];
          nxt[4:0] = 5'h12;
          mid      = q[5];
        end
        5'h12:   nxt[4:0] = 5'h01;
        default: nxt[4:0] = inc12[4:0];
      endcase
    end else begin
      if (q[5:0] == 6'h23) begin
        nxt[5:0] = 6'h00;
        mid      = 1'b1;
      end else begin
        nxt[5:0] = inc24[5:0];
      end
    end
  end

  assign day_o = inc_i && mid;
  assign val_o = {1'b0, q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q <= 7'h00;
    else if (wr_i)  q <= wr_data_i[6:0];
    else if (inc_i) q <= nxt;
  end
endmodule

// File: rtl/bcd_clock_calendar.sv
module bcd_clock_calendar
  import bcd_cal_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [BYTE_W-1:0]   wr_data_i,
  output logic [BYTE_W-1:0]   sec_o,
  output logic [BYTE_W-1:0]   min_o,
  output logic [BYTE_W-1:0]   hour_o,
  output logic [BYTE_W-1:0]   wday_o,
  output logic [BYTE_W-1:0]   date_o,
  output logic [BYTE_W-1:0]   month_o,
  output logic [BYTE_W-1:0]   year_o
);
  logic [N_FLD-1:0] wr_hit;
  logic             halt_q, run;
  logic             sec_wrap, min_wrap, day_step, wday_wrap, date_wrap, mon_wrap, year_wrap;
  bcd8_t            sec_v, min_v, hour_v, wday_v, date_v, mon_v, year_v;

  for (genvar i = 0; i < N_FLD; i++) begin : g_dec
    assign wr_hit[i] = wr_en_i && (wr_addr_i == ADDR_W'(i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            halt_q <= 1'b0;
    else if (wr_hit[F_SEC]) halt_q <= wr_data_i[7];
  end

  assign run = tick_i && !halt_q;

  bcd_field_cnt #(.LO(8'h00), .RST(8'h00), .MASK(8'h7F)) u_sec (
    .clk_i, .rst_ni, .inc_i(run), .top_i(8'h59),
    .wr_i(wr_hit[F_SEC]), .wr_data_i, .val_o(sec_v), .wrap_o(sec_wrap));

  bcd_field_cnt #(.LO(8'h00), .RST(8'h00), .MASK(8'h7F)) u_min (
    .clk_i, .rst_ni, .inc_i(sec_wrap), .top_i(8'h59),
    .wr_i(wr_hit[F_MIN]), .wr_data_i, .val_o(min_v), .wrap_o(min_wrap));

  bcd_hour_cnt u_hour (
    .clk_i, .rst_ni, .inc_i(min_wrap),
    .wr_i(wr_hit[F_HOUR]), .wr_data_i, .val_o(hour_v), .day_o(day_step));

  bcd_field_cnt #(.LO(8'h01), .RST(8'h01), .MASK(8'h07)) u_wday (
    .clk_i, .rst_ni, .inc_i(day_step), .top_i(8'h07),
    .wr_i(wr_hit[F_WDAY]), .wr_data_i, .val_o(wday_v), .wrap_o(wday_wrap));

  bcd_field_cnt #(.LO(8'h01), .RST(8'h01), .MASK(8'h3F)) u_date (
    .clk_i, .rst_ni, .inc_i(day_step), .top_i(last_day(mon_v, year_v)),
    .wr_i(wr_hit[F_DATE]), .wr_data_i, .val_o(date_v), .wrap_o(date_wrap));

  bcd_field_cnt #(.LO(8'h01), .RST(8'h01), .MASK(8'h1F)) u_month (
    .clk_i, .rst_ni, .inc_i(date_wrap), .top_i(8'h12),
    .wr_i(wr_hit[F_MONTH]), .wr_data_i, .val_o(mon_v), .wrap_o(mon_wrap));

  bcd_field_cnt #(.LO(8'h00), .RST(8'h00), .MASK(8'hFF)) u_year (
    .clk_i, .rst_ni, .inc_i(mon_wrap), .top_i(8'h99),
    .wr_i(wr_hit[F_YEAR]), .wr_data_i, .val_o(year_v), .wrap_o(year_wrap));

  assign sec_o   = {halt_q, sec_v[6:0]};
  assign min_o   = min_v;
  assign hour_o  = hour_v;
  assign wday_o  = wday_v;
  assign date_o  = date_v;
  assign month_o = mon_v;
  assign year_o  = year_v;
endmodule

// File: rtl/bcd_clock_calendar_chk.sv
module bcd_clock_calendar_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       wr_en_i,
  input logic [2:0] wr_addr_i,
  input logic [7:0] wr_data_i,
  input logic [7:0] sec_o,
  input logic [7:0] min_o,
  input logic [7:0] hour_o,
  input logic [7:0] wday_o,
  input logic [7:0] date_o,
  input logic [7:0] month_o,
  input logic [7:0] year_o
);
  // R9
  fixed_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    min_o[7] == 1'b0 && hour_o[7] == 1'b0 && wday_o[7:3] == 5'd0 &&
    date_o[7:6] == 2'd0 && month_o[7:5] == 3'd0);

  // R3
  halt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_o[7] && !wr_en_i) |=> ($stable(sec_o) && $stable(min_o) && $stable(hour_o) &&
      $stable(wday_o) && $stable(date_o) && $stable(month_o) && $stable(year_o)));

  // R11
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_en_i) |=> ($stable(sec_o) && $stable(min_o) && $stable(hour_o) &&
      $stable(wday_o) && $stable(date_o) && $stable(month_o) && $stable(year_o)));

  // R9
  min_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 3'd1) |=> min_o == {1'b0, $past(wr_data_i[6:0])});

  // R9
  year_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 3'd6) |=> year_o == $past(wr_data_i));

  // R2
  sec_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !sec_o[7] && !wr_en_i && sec_o[6:0] == 7'h59) |=>
      (sec_o[6:0] == 7'h00 && min_o != $past(min_o)));

  // R6
  wday_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_en_i && sec_o == 8'h59 && min_o == 8'h59 && hour_o == 8'h23 &&
     wday_o == 8'h07) |=> wday_o == 8'h01);
endmodule

bind bcd_clock_calendar bcd_clock_calendar_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .wr_en_i(wr_en_i),
  .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .sec_o(sec_o), .min_o(min_o),
  .hour_o(hour_o), .wday_o(wday_o), .date_o(date_o), .month_o(month_o), .year_o(year_o));

// File: tb/bcd_clock_calendar_tb.sv
`timescale 1ns/1ps
module bcd_clock_calendar_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = 3'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] sec, mins, hour, wday, date, month, year;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // reference state, binary
  int m_sec = 0, m_min = 0, m_hr = 0, m_wday = 1, m_date = 1, m_mon = 1, m_year = 0;
  bit m_halt = 0, m_12 = 0;

  always #2 clk = ~clk;

  bcd_clock_calendar u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .sec_o(sec), .min_o(mins),
    .hour_o(hour), .wday_o(wday), .date_o(date), .month_o(month), .year_o(year));

  function automatic logic [7:0] to_bcd(input int x);
    return 8'(((x / 10) << 4) | (x % 10));
  endfunction

  function automatic int from_bcd(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic int mdays(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] exp_byte(input int a);
    int h;
    case (a)
      0: return {m_halt, to_bcd(m_sec)[6:0]};
      1: return to_bcd(m_min);
      2: begin
        if (m_12) begin
          h = m_hr % 12;
          if (h == 0) h = 12;
          return {2'b01, (m_hr >= 12), to_bcd(h)[4:0]};
        end
        return {2'b00, to_bcd(m_hr)[5:0]};
      end
      3: return 8'(m_wday);
      4: return to_bcd(m_date);
      5: return to_bcd(m_mon);
      default: return to_bcd(m_year);
    endcase
  endfunction

  task automatic model_tick();
    if (m_halt) return;
    m_sec++;
    if (m_sec < 60) return;
    m_sec = 0; m_min++;
    if (m_min < 60) return;
    m_min = 0; m_hr++;
    if (m_hr < 24) return;
    m_hr = 0;
    m_wday = (m_wday == 7) ? 1 : m_wday + 1;
    m_date++;
    if (m_date <= mdays(m_mon, m_year)) return;
    m_date = 1; m_mon++;
    if (m_mon < 13) return;
    m_mon = 1; m_year = (m_year + 1) % 100;
  endtask

  task automatic model_write(input int a, input logic [7:0] d);
    int h;
    case (a)
      0: begin m_halt = d[7]; m_sec = from_bcd({1'b0, d[6:0]}); end
      1: m_min = from_bcd({1'b0, d[6:0]});
      2: begin
        m_12 = d[6];
        if (d[6]) begin
          h = from_bcd({3'b000, d[4:0]});
          m_hr = (h % 12) + (d[5] ? 12 : 0);
        end else m_hr = from_bcd({2'b00, d[5:0]});
      end
      3: m_wday = int'(d[2:0]);
      4: m_date = from_bcd({2'b00, d[5:0]});
      5: m_mon = from_bcd({3'b000, d[4:0]});
      6: m_year = from_bcd(d);
      default: ;
    endcase
  endtask

  function automatic logic [7:0] act_byte(input int a);
    case (a)
      0: return sec;
      1: return mins;
      2: return hour;
      3: return wday;
      4: return date;
      5: return month;
      default: return year;
    endcase
  endfunction

  task automatic check_all(input string tag);
    for (int a = 0; a < 7; a++) begin
      total++;
      if (act_byte(a) !== exp_byte(a)) begin
        bad++;
        $display("FAIL %s field%0d actual=%02h expected=%02h", tag, a, act_byte(a), exp_byte(a));
      end
    end
  endtask

  task automatic step(input bit tk, input bit we, input int a, input logic [7:0] d, input string tag);
    @(negedge clk);
    tick = tk; wr_en = we; wr_addr = 3'(a); wr_data = d;
    @(posedge clk);
    if (tk) model_tick();
    if (we) model_write(a, d);
    #1;
    check_all(tag);
  endtask

  task automatic wr(input int a, input logic [7:0] d, input string tag);
    step(1'b0, 1'b1, a, d, tag);
  endtask

  task automatic tk(input string tag);
    step(1'b1, 1'b0, 0, 8'h00, tag);
  endtask

  task automatic set_all(input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h,
                         input logic [7:0] wd, input logic [7:0] dt, input logic [7:0] mo,
                         input logic [7:0] y, input string tag);
    wr(6, y, tag); wr(5, mo, tag); wr(4, dt, tag); wr(3, wd, tag);
    wr(2, h, tag); wr(1, mi, tag); wr(0, s, tag);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int a;
    logic [7:0] d;
    int unused_seed;
    unused_seed = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    #1 check_all("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk); #1 check_all("R1 after reset");

    // R4 R6 R7: non-leap Feb end at midnight, weekday 7 -> 1
    set_all(8'h58, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h23, "R4 setup");
    tk("R2"); tk("R6 R7 R4 midnight");
    // R7 leap year
    set_all(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24, "R7 setup");
    tk("R7 leap to 29");
    wr(2, 8'h23, "R7"); wr(1, 8'h59, "R7"); wr(0, 8'h59, "R7");
    tk("R7 leap 29 to Mar 1");
    // R7 30-day month
    set_all(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h10, "R7 setup");
    tk("R7 Apr30 to May1");
    // R8 year wrap
    set_all(8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h99, "R8 setup");
    tk("R8 year 99 to 00");
    // R5 12-hour
    set_all(8'h59, 8'h59, 8'h51, 8'h01, 8'h10, 8'h06, 8'h05, "R5 setup");
    tk("R5 11AM to 12PM");
    wr(1, 8'h59, "R5"); wr(0, 8'h59, "R5");
    tk("R5 12PM to 1PM");
    wr(2, 8'h52, "R5"); wr(1, 8'h59, "R5"); wr(0, 8'h59, "R5");
    tk("R5 12AM to 1AM");
    wr(2, 8'h71, "R5"); wr(1, 8'h59, "R5"); wr(0, 8'h59, "R5");
    tk("R5 11PM to 12AM midnight");
    // R3 halt
    wr(0, 8'hB0, "R3 set halt");
    tk("R3 halted"); tk("R3 halted"); tk("R3 halted");
    wr(0, 8'h30, "R3 release");
    tk("R3 running");
    // R9 masks and unused index
    wr(1, 8'h85, "R9 min mask"); wr(2, 8'h95, "R9 hour mask");
    wr(3, 8'hF3, "R9 wday mask"); wr(4, 8'hC7, "R9 date mask");
    wr(5, 8'hE9, "R9 month mask"); wr(7, 8'h55, "R9 index 7 ignored");
    // R10 write with tick
    set_all(8'h59, 8'h20, 8'h10, 8'h02, 8'h07, 8'h09, 8'h30, "R10 setup");
    step(1'b1, 1'b1, 1, 8'h05, "R10 min write wins");
    wr(1, 8'h59, "R10"); wr(0, 8'h59, "R10");
    step(1'b1, 1'b1, 1, 8'h30, "R10 carry from old min");
    step(1'b1, 1'b1, 0, 8'h45, "R10 sec write wins");
    // R11 idle
    repeat (4) step(1'b0, 1'b0, 0, 8'h00, "R11 idle");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      a = $urandom_range(0, 6);
      case (a)
        0: d = {($urandom_range(0, 15) == 0), to_bcd(($urandom_range(0, 2) == 0) ? 59 : $urandom_range(0, 59))[6:0]};
        1: d = to_bcd(($urandom_range(0, 2) == 0) ? 59 : $urandom_range(0, 59));
        2: if ($urandom_range(0, 1) == 1)
             d = {2'b01, 1'($urandom_range(0, 1)), to_bcd(($urandom_range(0, 1) == 1) ? 11 + $urandom_range(0, 1) : $urandom_range(1, 12))[4:0]};
           else
             d = to_bcd(($urandom_range(0, 2) == 0) ? 23 : $urandom_range(0, 23));
        3: d = 8'($urandom_range(1, 7));
        4: d = to_bcd($urandom_range(1, 28));
        5: if (m_date > 28) begin a = 1; d = to_bcd($urandom_range(0, 59)); end
           else d = to_bcd($urandom_range(1, 12));
        default: if (m_mon == 2 && m_date == 29) begin a = 1; d = 8'h59; end
                 else d = to_bcd($urandom_range(0, 99));
      endcase
      step(1'($urandom_range(0, 1)), ($urandom_range(0, 4) == 0), a, d, "R2 R10 random");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule